// File: doc/BRIEF.md
# Bus Command List Sequencer

This block steps through a program of bus commands held in a small instruction memory and runs each one against a modular crate bus. A command names a station, a subaddress and a function code. The function code alone decides whether the command moves data. Codes 0 to 7 fetch a 24-bit word from the bus into a local data memory at the read pointer. Codes 16 to 23 send the word at the write pointer out to the bus. Every other code is a control action with no data phase. Two command opcodes exist. One obeys the Q response flag from the bus, and the other ignores it and always moves on.

Execution is driven by triggers. The first seven instruction words form a dispatch table, and trigger number k starts at address k-1. Each table entry is normally either a stop or an unconditional jump to a handler list. A handler ends with a wait-for-trigger jump that parks the sequencer until the next trigger arrives. A trigger that comes in while a handler is still running is held and serviced at the next wait. A host loads the instruction memory, the two pointers, the instruction pointer and the data memory, and gates execution with an enable.

Top module: `cmdlist_seq`

## Requirements
- R1: After reset, `busy` and `cmd_req` are 0, and `ip`, `rptr` and `wptr` are all 0.
- R2: A Q-obeying command (opcode 1) with a function code from 0 to 7 that completes with `cmd_q`=1 stores `cmd_rdata` at the old `rptr`, and `rptr` then increments by one.
- R3: While a command with a function code from 16 to 23 is requested, `cmd_wdata` shows the data word at `wptr`. When it completes with the transfer allowed, `wptr` increments by one.
- R4: A command whose function code is outside 0–7 and 16–23 changes neither pointer and stores nothing.
- R5: A Q-obeying command that completes with `cmd_q`=0 stores nothing and leaves both pointers unchanged.
- R6: A Q-ignoring command (opcode 2) always advances the pointer its function code selects, whatever the value of `cmd_q`. For a read it stores `cmd_rdata`.
- R7: An instruction word is {opcode[16:14], fn[13:9], sub[8:5], station[4:0]}, and a jump target sits in the low bits. An unconditional jump (opcode 3) loads `ip` with its target. A trigger k (1..7) that is taken while waiting loads `ip` with k-1 on the next clock.
- R8: A wait-for-trigger jump (opcode 4) loads `ip` with its target and then holds there with `cmd_req` low and `busy` high until a trigger is taken.
- R9: A stop (opcode 0, or any unused opcode) clears `busy`, holds `ip`, and issues no further commands.
- R10: While `en` is 0, the instruction pointer and the data pointers do not advance, and triggers are not taken or latched.
- R11: A trigger that arrives while a list is running is latched and dispatched at the next wait-for-trigger.
- R12: `cmd_req` stays high, with stable command fields, until `cmd_done`. The instruction pointer moves to the next address only after `cmd_done`.
- R13: A host write to the instruction pointer loads `ip` on the next clock, sets `busy` and resumes execution from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execution enable |
| iw_en | input | 1 | Instruction memory write strobe |
| iw_addr | input | 6 | Instruction memory write address |
| iw_data | input | 17 | Instruction word |
| ipw_en | input | 1 | Instruction pointer load |
| ipw_val | input | 6 | Instruction pointer load value |
| rpw_en | input | 1 | Read pointer load |
| rpw_val | input | 5 | Read pointer load value |
| wpw_en | input | 1 | Write pointer load |
| wpw_val | input | 5 | Write pointer load value |
| hw_en | input | 1 | Host data memory write strobe |
| hw_addr | input | 5 | Host data memory write address |
| hw_data | input | 24 | Host data memory write word |
| hr_addr | input | 5 | Host data memory read address |
| hr_data | output | 24 | Host data memory read word |
| trig_valid | input | 1 | Trigger strobe |
| trig_num | input | 3 | Trigger number 1..7 |
| cmd_req | output | 1 | Bus command request |
| cmd_station | output | 5 | Command station |
| cmd_sub | output | 4 | Command subaddress |
| cmd_fn | output | 5 | Command function code |
| cmd_wdata | output | 24 | Data word for write commands |
| cmd_done | input | 1 | Bus command completion |
| cmd_q | input | 1 | Q response, valid with cmd_done |
| cmd_rdata | input | 24 | Read data, valid with cmd_done |
| busy | output | 1 | List armed or running |
| ip | output | 6 | Instruction pointer |
| rptr | output | 5 | Read data pointer |
| wptr | output | 5 | Write data pointer |

## Verification
The bench runs a command table that crosses both opcodes with read, write and no-data function codes at the edges of each range (0, 7, 16, 23, 8, 15, 24) and with both Q values. This separates the Q-obeying opcode from the Q-ignoring one, and separates each function class from the others. It checks pointer steps and the word stored at the old read pointer, against a sentinel the bench writes there first. A dispatch program then tests the trigger path. It drives trigger 7 to a jump and trigger 2 to a stop. It fires a trigger while a command is outstanding, which shows whether that trigger is latched or lost. It fires another with the enable low, which shows whether triggers are ignored when disabled.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    localparam int DATA_W = 24;
    localparam int STA_W  = 5;
    localparam int SUB_W  = 4;
    localparam int FN_W   = 5;
    localparam int OP_W   = 3;
    localparam int INSTR_W = OP_W + FN_W + SUB_W + STA_W;

    typedef enum logic [OP_W-1:0] {
        OP_STOP  = 3'd0,
        OP_QRESP = 3'd1,
        OP_QIGN  = 3'd2,
        OP_JMP   = 3'd3,
        OP_JTRG  = 3'd4
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [FN_W-1:0]  fn;
        logic [SUB_W-1:0] sub;
        logic [STA_W-1:0] sta;
    } instr_t;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMD  = 2'd2,
        ST_WAIT = 2'd3
    } state_e;

    // Function code classes: 0..7 read, 16..23 write, rest no data.
    function automatic xfer_e fn_class(input logic [FN_W-1:0] fn);
        case (fn[4:3])
            2'b00:   return XF_READ;
            2'b10:   return XF_WRITE;
            default: return XF_NONE;
        endcase
    endfunction

    function automatic logic is_cmd(input logic [OP_W-1:0] op);
        return (op == OP_QRESP) || (op == OP_QIGN);
    endfunction

endpackage

// File: rtl/cls_imem.sv
module cls_imem #(
    parameter int AW = 6,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cls_dmem.sv
module cls_dmem #(
    parameter int AW = 5,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_waddr,
    input  logic [DW-1:0] seq_wdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Sequencer stores take priority over host writes.
    always_ff @(posedge clk) begin
        if (seq_we)       mem[seq_waddr]  <= seq_wdata;
        else if (host_we) mem[host_waddr] <= host_wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cls_dptr.sv
module cls_dptr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rload,
    input  logic [AW-1:0] rval,
    input  logic          rinc,
    input  logic          wload,
    input  logic [AW-1:0] wval,
    input  logic          winc,
    output logic [AW-1:0] rptr,
    output logic [AW-1:0] wptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            wptr <= '0;
        end else begin
            if (rload)     rptr <= rval;
            else if (rinc) rptr <= rptr + 1'b1;
            if (wload)     wptr <= wval;
            else if (winc) wptr <= wptr + 1'b1;
        end
    end
endmodule

// File: rtl/cls_ctrl.sv
module cls_ctrl
    import cmdlist_pkg::*;
#(
    parameter int IAW    = 6,
    parameter int N_TRIG = 7,
    parameter int TRIG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ipw_en,
    input  logic [IAW-1:0]   ipw_val,
    input  logic [OP_W-1:0]  op,
    input  logic [FN_W-1:0]  fn,
    input  logic [IAW-1:0]   target,
    input  logic             trig_valid,
    input  logic [TRIG_W-1:0] trig_num,
    input  logic             cmd_done,
    input  logic             cmd_q,
    output logic [IAW-1:0]   ip,
    output logic             busy,
    output logic             cmd_req,
    output logic             rinc,
    output logic             winc
);
    state_e            state;
    logic              pend;
    logic [TRIG_W-1:0] pend_num;
    logic              trig_hit;
    logic              take;
    logic [TRIG_W-1:0] take_num;
    logic              done_fire;
    logic              go;
    xfer_e             xf;

    assign trig_hit = en && trig_valid && (trig_num != '0)
                      && (int'(trig_num) <= N_TRIG);
    assign take     = en && !ipw_en && (state == ST_WAIT) && (trig_hit || pend);
    assign take_num = trig_hit ? trig_num : pend_num;

    assign xf        = fn_class(fn);
    assign done_fire = en && !ipw_en && (state == ST_CMD) && cmd_done;
    assign go        = (op == OP_QIGN) || cmd_q;
    assign rinc      = done_fire && go && (xf == XF_READ);
    assign winc      = done_fire && go && (xf == XF_WRITE);

    // Trigger latch: a newer trigger replaces an older unserviced one.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_num <= '0;
        end else if (take) begin
            pend <= 1'b0;
        end else if (trig_hit) begin
            pend     <= 1'b1;
            pend_num <= trig_num;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HALT;
            ip      <= '0;
            busy    <= 1'b0;
            cmd_req <= 1'b0;
        end else if (ipw_en) begin
            ip      <= ipw_val;
            state   <= ST_RUN;
            busy    <= 1'b1;
            cmd_req <= 1'b0;
        end else if (en) begin
            case (state)
                ST_RUN: begin
                    case (op)
                        OP_JMP:  ip <= target;
                        OP_JTRG: begin
                            ip    <= target;
                            state <= ST_WAIT;
                        end
                        OP_QRESP, OP_QIGN: begin
                            cmd_req <= 1'b1;
                            state   <= ST_CMD;
                        end
                        default: begin
                            busy  <= 1'b0;
                            state <= ST_HALT;
                        end
                    endcase
                end
                ST_CMD: begin
                    if (cmd_done) begin
                        cmd_req <= 1'b0;
                        ip      <= ip + 1'b1;
                        state   <= ST_RUN;
                    end
                end
                ST_WAIT: begin
                    if (take) begin
                        ip    <= IAW'(take_num) - 1'b1;
                        state <= ST_RUN;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmdlist_seq.sv
module cmdlist_seq
    import cmdlist_pkg::*;
#(
    parameter int IAW    = 6,
    parameter int DAW    = 5,
    parameter int N_TRIG = 7,
    parameter int TRIG_W = $clog2(N_TRIG + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               iw_en,
    input  logic [IAW-1:0]     iw_addr,
    input  logic [INSTR_W-1:0] iw_data,
    input  logic               ipw_en,
    input  logic [IAW-1:0]     ipw_val,
    input  logic               rpw_en,
    input  logic [DAW-1:0]     rpw_val,
    input  logic               wpw_en,
    input  logic [DAW-1:0]     wpw_val,
    input  logic               hw_en,
    input  logic [DAW-1:0]     hw_addr,
    input  logic [DATA_W-1:0]  hw_data,
    input  logic [DAW-1:0]     hr_addr,
    output logic [DATA_W-1:0]  hr_data,
    input  logic               trig_valid,
    input  logic [TRIG_W-1:0]  trig_num,
    output logic               cmd_req,
    output logic [STA_W-1:0]   cmd_station,
    output logic [SUB_W-1:0]   cmd_sub,
    output logic [FN_W-1:0]    cmd_fn,
    output logic [DATA_W-1:0]  cmd_wdata,
    input  logic               cmd_done,
    input  logic               cmd_q,
    input  logic [DATA_W-1:0]  cmd_rdata,
    output logic               busy,
    output logic [IAW-1:0]     ip,
    output logic [DAW-1:0]     rptr,
    output logic [DAW-1:0]     wptr
);
    logic [INSTR_W-1:0] iword;
    instr_t             ins;
    logic               rinc;
    logic               winc;

    assign ins = instr_t'(iword);

    cls_imem #(.AW(IAW), .DW(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (iw_en),
        .waddr (iw_addr),
        .wdata (iw_data),
        .raddr (ip),
        .rdata (iword)
    );

    cls_ctrl #(.IAW(IAW), .N_TRIG(N_TRIG), .TRIG_W(TRIG_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .ipw_en     (ipw_en),
        .ipw_val    (ipw_val),
        .op         (ins.op),
        .fn         (ins.fn),
        .target     (iword[IAW-1:0]),
        .trig_valid (trig_valid),
        .trig_num   (trig_num),
        .cmd_done   (cmd_done),
        .cmd_q      (cmd_q),
        .ip         (ip),
        .busy       (busy),
        .cmd_req    (cmd_req),
        .rinc       (rinc),
        .winc       (winc)
    );

    cls_dptr #(.AW(DAW)) u_dptr (
        .clk   (clk),
        .rst   (rst),
        .rload (rpw_en),
        .rval  (rpw_val),
        .rinc  (rinc),
        .wload (wpw_en),
        .wval  (wpw_val),
        .winc  (winc),
        .rptr  (rptr),
        .wptr  (wptr)
    );

    cls_dmem #(.AW(DAW), .DW(DATA_W)) u_dmem (
        .clk        (clk),
        .seq_we     (rinc),
        .seq_waddr  (rptr),
        .seq_wdata  (cmd_rdata),
        .host_we    (hw_en),
        .host_waddr (hw_addr),
        .host_wdata (hw_data),
        .raddr_a    (hr_addr),
        .rdata_a    (hr_data),
        .raddr_b    (wptr),
        .rdata_b    (cmd_wdata)
    );

    assign cmd_station = ins.sta;
    assign cmd_sub     = ins.sub;
    assign cmd_fn      = ins.fn;
endmodule

// File: rtl/cmdlist_seq_chk.sv
module cmdlist_seq_chk #(
    parameter int IAW = 6,
    parameter int DAW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           iw_en,
    input logic           ipw_en,
    input logic           rpw_en,
    input logic           wpw_en,
    input logic           cmd_req,
    input logic           cmd_done,
    input logic [4:0]     cmd_fn,
    input logic [4:0]     cmd_station,
    input logic           busy,
    input logic [IAW-1:0] ip,
    input logic [DAW-1:0] rptr,
    input logic [DAW-1:0] wptr
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_done && !ipw_en) |=> cmd_req); // R12

    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_done && !ipw_en && !iw_en)
        |=> ($stable(cmd_fn) && $stable(cmd_station) && $stable(ip))); // R12

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!rpw_en && !cmd_done) |=> $stable(rptr)); // R2

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wpw_en) |=> (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1)); // R3

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!en && !ipw_en && !rpw_en && !wpw_en)
        |=> ($stable(ip) && $stable(rptr) && $stable(wptr))); // R10

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (!cmd_req)); // R9
endmodule

bind cmdlist_seq cmdlist_seq_chk #(.IAW(IAW), .DAW(DAW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .iw_en       (iw_en),
    .ipw_en      (ipw_en),
    .rpw_en      (rpw_en),
    .wpw_en      (wpw_en),
    .cmd_req     (cmd_req),
    .cmd_done    (cmd_done),
    .cmd_fn      (cmd_fn),
    .cmd_station (cmd_station),
    .busy        (busy),
    .ip          (ip),
    .rptr        (rptr),
    .wptr        (wptr)
);

// File: tb/cmdlist_seq_bench.sv
module cmdlist_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        iw_en = 1'b0;
    logic [5:0]  iw_addr = '0;
    logic [16:0] iw_data = '0;
    logic        ipw_en = 1'b0;
    logic [5:0]  ipw_val = '0;
    logic        rpw_en = 1'b0;
    logic [4:0]  rpw_val = '0;
    logic        wpw_en = 1'b0;
    logic [4:0]  wpw_val = '0;
    logic        hw_en = 1'b0;
    logic [4:0]  hw_addr = '0;
    logic [23:0] hw_data = '0;
    logic [4:0]  hr_addr = '0;
    logic [23:0] hr_data;
    logic        trig_valid = 1'b0;
    logic [2:0]  trig_num = '0;
    logic        cmd_req;
    logic [4:0]  cmd_station;
    logic [3:0]  cmd_sub;
    logic [4:0]  cmd_fn;
    logic [23:0] cmd_wdata;
    logic        cmd_done = 1'b0;
    logic        cmd_q = 1'b0;
    logic [23:0] cmd_rdata = '0;
    logic        busy;
    logic [5:0]  ip;
    logic [4:0]  rptr;
    logic [4:0]  wptr;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    cmdlist_seq u_cmdlist_seq (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  fn;
        logic        q;
        logic [23:0] rd;
        logic        ri;
        logic        wi;
    } vec_t;

    // op 1 = obeys Q, op 2 = ignores Q
    localparam vec_t VECS [10] = '{
        '{3'd1, 5'd0,  1'b1, 24'h123456, 1'b1, 1'b0},
        '{3'd1, 5'd7,  1'b0, 24'h0BAD01, 1'b0, 1'b0},
        '{3'd1, 5'd16, 1'b1, 24'h000000, 1'b0, 1'b1},
        '{3'd1, 5'd23, 1'b0, 24'h000000, 1'b0, 1'b0},
        '{3'd2, 5'd3,  1'b0, 24'hC0FFEE, 1'b1, 1'b0},
        '{3'd2, 5'd20, 1'b0, 24'h000000, 1'b0, 1'b1},
        '{3'd1, 5'd8,  1'b1, 24'h0BAD02, 1'b0, 1'b0},
        '{3'd2, 5'd24, 1'b1, 24'h0BAD03, 1'b0, 1'b0},
        '{3'd2, 5'd15, 1'b0, 24'h0BAD04, 1'b0, 1'b0},
        '{3'd1, 5'd5,  1'b1, 24'h7E5A11, 1'b1, 1'b0}
    };

    function automatic string req_of(input logic [2:0] op, input logic [4:0] fn, input logic q);
        if (!(fn < 8 || (fn >= 16 && fn <= 23))) return "R4";
        if (op == 3'd2) return "R6";
        if (!q) return "R5";
        return (fn < 8) ? "R2" : "R3";
    endfunction

    function automatic logic [16:0] mk(input logic [2:0] op, input logic [4:0] fn,
                                       input logic [3:0] sub, input logic [4:0] sta);
        return {op, fn, sub, sta};
    endfunction

    function automatic logic [16:0] mkj(input logic [2:0] op, input logic [5:0] tgt);
        return {op, 8'd0, tgt};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic iwrite(input logic [5:0] a, input logic [16:0] d);
        @(negedge clk); iw_en = 1'b1; iw_addr = a; iw_data = d;
        @(negedge clk); iw_en = 1'b0;
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [23:0] d);
        @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    task automatic ipload(input logic [5:0] v);
        @(negedge clk); ipw_en = 1'b1; ipw_val = v;
        @(negedge clk); ipw_en = 1'b0;
    endtask

    task automatic pulse_trig(input logic [2:0] k);
        @(negedge clk); trig_valid = 1'b1; trig_num = k;
        @(negedge clk); trig_valid = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        got = 0;
        for (int c = 0; c < 12; c++) begin
            if (cmd_req) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic respond(input logic q, input logic [23:0] d);
        cmd_done = 1'b1; cmd_q = q; cmd_rdata = d;
        @(negedge clk);
        cmd_done = 1'b0; cmd_q = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        int mr;
        int mw;
        bit got;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0,    "R1", "busy",    busy, 0);
        chk(cmd_req == 1'b0, "R1", "cmd_req", cmd_req, 0);
        chk(ip == 6'd0,      "R1", "ip",      ip, 0);
        chk(rptr == 5'd0,    "R1", "rptr",    rptr, 0);
        chk(wptr == 5'd0,    "R1", "wptr",    wptr, 0);

        // Preload write data and pointers
        for (int a = 16; a < 32; a++) hwrite(5'(a), 24'hA50000 + 24'(a));
        @(negedge clk); rpw_en = 1'b1; rpw_val = 5'd0; wpw_en = 1'b1; wpw_val = 5'd16;
        @(negedge clk); rpw_en = 1'b0; wpw_en = 1'b0;
        mr = 0; mw = 16;
        en = 1'b1;

        // Command table walk
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            string rq;
            v  = VECS[i];
            rq = req_of(v.op, v.fn, v.q);
            hwrite(5'(mr), 24'h5E0000 | 24'(i));
            iwrite(6'd40, mk(v.op, v.fn, 4'(i), 5'(i + 1)));
            iwrite(6'd41, mkj(3'd0, 6'd0));
            ipload(6'd40);
            wait_req(got);
            chk(got, "R12", "cmd_req raised", got, 1);
            chk(cmd_fn == v.fn, rq, "cmd_fn", cmd_fn, v.fn);
            if (v.wi) chk(cmd_wdata == 24'hA50000 + 24'(mw), "R3", "cmd_wdata",
                          cmd_wdata, 24'hA50000 + 24'(mw));
            repeat (2) @(negedge clk);
            chk(cmd_req && ip == 6'd40 && cmd_station == 5'(i + 1), "R12",
                "request held", {cmd_req, ip}, {1'b1, 6'd40});
            respond(v.q, v.rd);
            chk(rptr == 5'(mr + int'(v.ri)), rq, "rptr", rptr, 5'(mr + int'(v.ri)));
            chk(wptr == 5'(mw + int'(v.wi)), rq, "wptr", wptr, 5'(mw + int'(v.wi)));
            hr_addr = 5'(mr);
            #1;
            if (v.ri) chk(hr_data == v.rd, rq, "stored word", hr_data, v.rd);
            else      chk(hr_data == (24'h5E0000 | 24'(i)), rq, "word untouched",
                          hr_data, 24'h5E0000 | 24'(i));
            mr = mr + int'(v.ri);
            mw = mw + int'(v.wi);
            repeat (2) @(negedge clk);
            chk(busy == 1'b0 && cmd_req == 1'b0, "R9", "stopped", {busy, cmd_req}, 0);
        end

        // Dispatch program
        iwrite(6'd0, mkj(3'd3, 6'd20));
        for (int a = 1; a < 6; a++) iwrite(6'(a), mkj(3'd0, 6'd0));
        iwrite(6'd6, mkj(3'd3, 6'd30));
        iwrite(6'd20, mk(3'd1, 5'd0, 4'd1, 5'd9));
        iwrite(6'd21, mkj(3'd4, 6'd0));
        iwrite(6'd30, mk(3'd2, 5'd17, 4'd2, 5'd4));
        iwrite(6'd31, mkj(3'd4, 6'd0));

        ipload(6'd21);
        // R13: pointer load takes effect
        chk(ip == 6'd21 && busy, "R13", "ip load", ip, 21);
        repeat (4) @(negedge clk);
        // R8: parked at wait target
        chk(ip == 6'd0 && !cmd_req && busy, "R8", "waiting", {busy, cmd_req, ip}, {1'b1, 1'b0, 6'd0});

        pulse_trig(3'd7);
        chk(ip == 6'd6, "R7", "trigger 7 entry", ip, 6);
        @(negedge clk);
        chk(ip == 6'd30, "R7", "jump target", ip, 30);
        @(negedge clk);
        chk(cmd_req && cmd_fn == 5'd17, "R7", "handler command", cmd_fn, 17);
        pulse_trig(3'd1);          // arrives while list runs
        respond(1'b0, 24'h0);      // Q ignored, write pointer advances
        chk(wptr == 5'(mw + 1), "R6", "wptr on Q=0", wptr, 5'(mw + 1));
        mw = mw + 1;
        wait_req(got);
        // R11: latched trigger 1 dispatched to entry 0 -> handler at 20
        chk(got && cmd_fn == 5'd0 && ip == 6'd20, "R11", "latched trigger", ip, 20);
        respond(1'b1, 24'h00AB12);
        chk(rptr == 5'(mr + 1), "R2", "rptr after read", rptr, 5'(mr + 1));
        mr = mr + 1;
        repeat (4) @(negedge clk);
        chk(ip == 6'd0 && !cmd_req, "R8", "back in wait", ip, 0);

        // R10: trigger while disabled is ignored
        @(negedge clk); en = 1'b0;
        pulse_trig(3'd7);
        repeat (2) @(negedge clk);
        chk(ip == 6'd0, "R10", "ip while disabled", ip, 0);
        en = 1'b1;
        repeat (4) @(negedge clk);
        chk(ip == 6'd0 && !cmd_req, "R10", "trigger dropped", ip, 0);

        // R9: trigger 2 hits a stop
        pulse_trig(3'd2);
        repeat (3) @(negedge clk);
        chk(!busy && ip == 6'd1 && !cmd_req, "R9", "halt", {busy, ip}, {1'b0, 6'd1});

        finish_run();
    end
endmodule